// File: doc/BRIEF.md
# Programmable Chip-Select and Ready Generator

This block turns a 20-bit bus address into active-low chip selects for several programmable regions. One select covers an upper memory region that always reaches the top of the 1 MB space. One select covers a lower memory region that starts at address zero. A mid-range memory block is split into four selects. A peripheral window gives seven selects, and it can sit in either memory space or I/O space.

Each region has its own 3-bit ready field. The field holds a wait count from 0 to 3 and a bit that says whether the external READY pin is ignored or combined with the internal wait counter. The control registers are loaded through a simple write port. When a bus cycle starts, the block latches the ready field of the region that was hit, counts down the waits and drives a bus ready output.

After reset only the upper region is active: it covers 1 KB and inserts 3 wait states while still honouring external READY. Every other region stays inactive until its register is written.

Top module: `csel_ready_gen`

## Requirements
- R1: While rst_ni is low, every chip-select output is high.
- R2: After reset the upper register holds 16'hFFFB. So ucs_n_o goes low only for memory addresses 20'hFFC00 to 20'hFFFFF, and each bus cycle there gets 3 waits with external READY combined.
- R3: Lower, mid and peripheral selects stay high after reset until their registers are written.
- R4: Write select 0 loads the upper register and write select 1 loads the lower register; both use data[15:6] as a 1 KB block number. ucs_n_o goes low when addr[19:10] >= that field, and lcs_n_o goes low when addr[19:10] <= that field. Data[2:0] is the region's ready field in every region register.
- R5: Write select 2 loads the mid base, with data[15:6] as the block number. Write select 3 loads a size code k in data[4:0], giving a block of 1 KB << k (codes above 8 act as 8). The block is cut into four equal quarters in address order, and quarter i drives mcs_n_o[i] low.
- R6: Write select 4 loads the peripheral register: data[15:6] is the base block and data[5] = 1 selects I/O space. Window i (0..6) is the 128 bytes at base + 128*i and drives pcs_n_o[i] low. The eighth 128-byte slot of the block decodes nothing.
- R7: In a ready field, bit [2] = 1 ignores external READY and bits [1:0] give the wait count w. A cycle starts when cyc_start_i is high at a clock edge. bus_ready_o is first high after w+1 edges, counted from and including the start edge, and stays high for one cycle only.
- R8: With bit [2] = 0, bus_ready_o is also held low until ext_ready_i is high.
- R9: With bit [2] = 1, ext_ready_i has no effect on when bus_ready_o rises.
- R10: An address that hits no active region drives no select and uses 0 waits with external READY combined.
- R11: Overlapping regions resolve by priority in the order upper, lower, mid, peripheral, so at most one select is low at a time.
- R12: I/O cycles (io_i = 1) never drive the memory selects. The peripheral selects follow io_i only when it matches the peripheral space bit.
- R13: Writes with wr_sel_i of 5, 6 or 7 change no region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 16 | Register write data |
| addr_i | input | 20 | Bus address |
| io_i | input | 1 | 1 = I/O-space cycle |
| cyc_start_i | input | 1 | Bus cycle start strobe |
| ext_ready_i | input | 1 | External READY pin |
| ucs_n_o | output | 1 | Upper memory select, active low |
| lcs_n_o | output | 1 | Lower memory select, active low |
| mcs_n_o | output | 4 | Mid-range selects, active low |
| pcs_n_o | output | 7 | Peripheral selects, active low |
| bus_ready_o | output | 1 | Bus ready to the bus controller |

## Verification
The assertions check on every cycle that the selects stay idle in reset, that at most one select is low, that I/O cycles never reach a memory select, that bus ready lasts a single cycle, and that bus ready rises with external READY low only in a cycle whose latched ready field ignores the pin. The exact wait latency for each count, the window and quarter boundaries, the reset contents of the upper region, the priority among overlapping regions and the ignored register selects depend on programmed values. Only the bench's directed scenarios can show these.

// File: rtl/csel_pkg.sv
package csel_pkg;
  parameter int ADDR_W       = 20;
  parameter int BLK_LOG2     = 10;
  parameter int FIELD_W      = ADDR_W - BLK_LOG2;
  parameter int REG_W        = 16;
  parameter int FIELD_LSB    = REG_W - FIELD_W;
  parameter int N_MCS        = 4;
  parameter int N_PCS        = 7;
  parameter int PCS_WIN_LOG2 = 7;
  parameter int PIDX_W       = BLK_LOG2 - PCS_WIN_LOG2;
  parameter int WAIT_W       = 2;
  parameter int RDY_W        = WAIT_W + 1;
  parameter int MSIZE_W      = 5;
  parameter int MSIZE_MAX    = 8;
  parameter int IO_BIT       = 5;
  parameter logic [REG_W-1:0] UCS_RST = 16'hFFFB;

  typedef struct packed {
    logic              ign;
    logic [WAIT_W-1:0] waits;
  } rdy_t;

  typedef enum logic [2:0] {
    SEL_UCS   = 3'd0,
    SEL_LCS   = 3'd1,
    SEL_MBASE = 3'd2,
    SEL_MSIZE = 3'd3,
    SEL_PCS   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [FIELD_W-1:0] ucs_fld_o,
  output logic [FIELD_W-1:0] lcs_fld_o,
  output logic [FIELD_W-1:0] mbase_fld_o,
  output logic [MSIZE_W-1:0] msize_o,
  output logic [FIELD_W-1:0] pbase_fld_o,
  output logic               p_io_o,
  output rdy_t               ucs_rdy_o,
  output rdy_t               lcs_rdy_o,
  output rdy_t               mcs_rdy_o,
  output rdy_t               pcs_rdy_o,
  output logic               l_vld_o,
  output logic               m_vld_o,
  output logic               p_vld_o
);
  logic [FIELD_W-1:0] fld;
  rdy_t               rdy;
  assign fld = wr_data_i[REG_W-1:FIELD_LSB];
  assign rdy = rdy_t'(wr_data_i[RDY_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ucs_fld_o   <= UCS_RST[REG_W-1:FIELD_LSB];
      ucs_rdy_o   <= rdy_t'(UCS_RST[RDY_W-1:0]);
      lcs_fld_o   <= '0;
      lcs_rdy_o   <= '0;
      mbase_fld_o <= '0;
      mcs_rdy_o   <= '0;
      msize_o     <= '0;
      pbase_fld_o <= '0;
      pcs_rdy_o   <= '0;
      p_io_o      <= 1'b0;
      l_vld_o     <= 1'b0;
      m_vld_o     <= 1'b0;
      p_vld_o     <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_UCS:   begin ucs_fld_o <= fld; ucs_rdy_o <= rdy; end
        SEL_LCS:   begin lcs_fld_o <= fld; lcs_rdy_o <= rdy; l_vld_o <= 1'b1; end
        SEL_MBASE: begin mbase_fld_o <= fld; mcs_rdy_o <= rdy; m_vld_o <= 1'b1; end
        SEL_MSIZE: msize_o <= wr_data_i[MSIZE_W-1:0];
        SEL_PCS: begin
          pbase_fld_o <= fld;
          pcs_rdy_o   <= rdy;
          p_io_o      <= wr_data_i[IO_BIT];
          p_vld_o     <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               io_i,
  input  logic [FIELD_W-1:0] ucs_fld_i,
  input  logic [FIELD_W-1:0] lcs_fld_i,
  input  logic [FIELD_W-1:0] mbase_fld_i,
  input  logic [MSIZE_W-1:0] msize_i,
  input  logic [FIELD_W-1:0] pbase_fld_i,
  input  logic               p_io_i,
  input  rdy_t               ucs_rdy_i,
  input  rdy_t               lcs_rdy_i,
  input  rdy_t               mcs_rdy_i,
  input  rdy_t               pcs_rdy_i,
  input  logic               l_vld_i,
  input  logic               m_vld_i,
  input  logic               p_vld_i,
  output logic               ucs_n_o,
  output logic               lcs_n_o,
  output logic [N_MCS-1:0]   mcs_n_o,
  output logic [N_PCS-1:0]   pcs_n_o,
  output rdy_t               sel_rdy_o
);
  logic [FIELD_W-1:0] a_blk;
  logic [ADDR_W-1:0]  m_base, m_off, m_span, m_qtr;
  logic [MSIZE_W-1:0] m_k;
  logic [PIDX_W-1:0]  p_idx;
  logic               u_hit, l_hit, m_hit, p_hit;

  assign a_blk  = addr_i[ADDR_W-1:BLK_LOG2];
  assign m_base = {mbase_fld_i, {BLK_LOG2{1'b0}}};
  assign m_off  = addr_i - m_base;
  assign m_k    = (msize_i > MSIZE_W'(MSIZE_MAX)) ? MSIZE_W'(MSIZE_MAX) : msize_i;
  assign m_span = m_off >> (BLK_LOG2 + int'(m_k));
  assign m_qtr  = m_off >> (BLK_LOG2 - 2 + int'(m_k));
  assign p_idx  = addr_i[BLK_LOG2-1:PCS_WIN_LOG2];

  // priority: upper > lower > mid > peripheral
  assign u_hit = !io_i && (a_blk >= ucs_fld_i);
  assign l_hit = !io_i && l_vld_i && (a_blk <= lcs_fld_i) && !u_hit;
  assign m_hit = !io_i && m_vld_i && (addr_i >= m_base) && (m_span == '0)
                 && !u_hit && !l_hit;
  assign p_hit = p_vld_i && (io_i == p_io_i) && (a_blk == pbase_fld_i)
                 && (int'(p_idx) < N_PCS) && !u_hit && !l_hit && !m_hit;

  assign ucs_n_o = !u_hit;
  assign lcs_n_o = !l_hit;

  for (genvar i = 0; i < N_MCS; i++) begin : g_mcs
    assign mcs_n_o[i] = !(m_hit && (m_qtr[1:0] == 2'(i)));
  end

  for (genvar i = 0; i < N_PCS; i++) begin : g_pcs
    assign pcs_n_o[i] = !(p_hit && (p_idx == PIDX_W'(i)));
  end

  always_comb begin
    sel_rdy_o = '0;
    if (u_hit)      sel_rdy_o = ucs_rdy_i;
    else if (l_hit) sel_rdy_o = lcs_rdy_i;
    else if (m_hit) sel_rdy_o = mcs_rdy_i;
    else if (p_hit) sel_rdy_o = pcs_rdy_i;
  end
endmodule

// File: rtl/csel_wait.sv
module csel_wait
  import csel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  input  rdy_t rdy_i,
  input  logic ext_ready_i,
  output logic bus_ready_o,
  output logic cur_ign_o
);
  logic              busy_q, ign_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ign_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (cyc_start_i) begin
      busy_q <= 1'b1;
      ign_q  <= rdy_i.ign;
      cnt_q  <= rdy_i.waits;
    end else if (busy_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (ign_q || ext_ready_i) busy_q <= 1'b0;
    end
  end

  assign bus_ready_o = busy_q && (cnt_q == '0) && (ign_q || ext_ready_i);
  assign cur_ign_o   = ign_q;
endmodule

// File: rtl/csel_ready_gen.sv
module csel_ready_gen
  import csel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               io_i,
  input  logic               cyc_start_i,
  input  logic               ext_ready_i,
  output logic               ucs_n_o,
  output logic               lcs_n_o,
  output logic [N_MCS-1:0]   mcs_n_o,
  output logic [N_PCS-1:0]   pcs_n_o,
  output logic               bus_ready_o
);
  logic [FIELD_W-1:0] ucs_fld, lcs_fld, mbase_fld, pbase_fld;
  logic [MSIZE_W-1:0] msize;
  logic               p_io, l_vld, m_vld, p_vld, cur_ign;
  rdy_t               ucs_rdy, lcs_rdy, mcs_rdy, pcs_rdy, sel_rdy;
  logic               d_ucs_n, d_lcs_n;
  logic [N_MCS-1:0]   d_mcs_n;
  logic [N_PCS-1:0]   d_pcs_n;

  csel_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ucs_fld_o(ucs_fld), .lcs_fld_o(lcs_fld), .mbase_fld_o(mbase_fld),
    .msize_o(msize), .pbase_fld_o(pbase_fld), .p_io_o(p_io),
    .ucs_rdy_o(ucs_rdy), .lcs_rdy_o(lcs_rdy), .mcs_rdy_o(mcs_rdy), .pcs_rdy_o(pcs_rdy),
    .l_vld_o(l_vld), .m_vld_o(m_vld), .p_vld_o(p_vld)
  );

  csel_decode u_dec (
    .addr_i, .io_i,
    .ucs_fld_i(ucs_fld), .lcs_fld_i(lcs_fld), .mbase_fld_i(mbase_fld),
    .msize_i(msize), .pbase_fld_i(pbase_fld), .p_io_i(p_io),
    .ucs_rdy_i(ucs_rdy), .lcs_rdy_i(lcs_rdy), .mcs_rdy_i(mcs_rdy), .pcs_rdy_i(pcs_rdy),
    .l_vld_i(l_vld), .m_vld_i(m_vld), .p_vld_i(p_vld),
    .ucs_n_o(d_ucs_n), .lcs_n_o(d_lcs_n), .mcs_n_o(d_mcs_n), .pcs_n_o(d_pcs_n),
    .sel_rdy_o(sel_rdy)
  );

  csel_wait u_wait (
    .clk_i, .rst_ni, .cyc_start_i, .rdy_i(sel_rdy), .ext_ready_i,
    .bus_ready_o, .cur_ign_o(cur_ign)
  );

  // selects forced idle while reset is held
  assign ucs_n_o = d_ucs_n | !rst_ni;
  assign lcs_n_o = d_lcs_n | !rst_ni;
  assign mcs_n_o = d_mcs_n | {N_MCS{!rst_ni}};
  assign pcs_n_o = d_pcs_n | {N_PCS{!rst_ni}};
endmodule

// File: rtl/csel_ready_gen_chk.sv
module csel_ready_gen_chk
  import csel_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             io_i,
  input logic             cyc_start_i,
  input logic             ext_ready_i,
  input logic             ucs_n_o,
  input logic             lcs_n_o,
  input logic [N_MCS-1:0] mcs_n_o,
  input logic [N_PCS-1:0] pcs_n_o,
  input logic             bus_ready_o,
  input logic             cur_ign
);
  logic [N_MCS+N_PCS+1:0] cs_act;
  assign cs_act = ~{ucs_n_o, lcs_n_o, mcs_n_o, pcs_n_o};

  always_comb begin
    if (!rst_ni) AST_RST_CS_IDLE: assert (cs_act == '0); // R1
  end

  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_act) <= 1); // R11

  AST_MCS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mcs_n_o)); // R5

  AST_IO_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_i |-> (ucs_n_o && lcs_n_o && (&mcs_n_o))); // R12

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ready_o && !cyc_start_i) |=> !bus_ready_o); // R7

  AST_EXT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ready_o && !ext_ready_i) |-> cur_ign); // R8
endmodule

bind csel_ready_gen csel_ready_gen_chk u_chk (
  .clk_i, .rst_ni, .io_i, .cyc_start_i, .ext_ready_i,
  .ucs_n_o, .lcs_n_o, .mcs_n_o, .pcs_n_o, .bus_ready_o, .cur_ign
);

// File: tb/csel_ready_gen_bench.sv
module csel_ready_gen_bench;
  localparam logic [12:0] NONE = 13'h1FFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [19:0] addr_i = '0;
  logic        io_i = 1'b0;
  logic        cyc_start_i = 1'b0;
  logic        ext_ready_i = 1'b1;
  logic        ucs_n_o, lcs_n_o, bus_ready_o;
  logic [3:0]  mcs_n_o;
  logic [6:0]  pcs_n_o;

  int checks = 0;
  int errors = 0;

  csel_ready_gen u_csel_ready_gen (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [12:0] cs_low(int pos);
    return NONE & ~(13'd1 << pos);
  endfunction

  task automatic check_cs(input logic [19:0] a, input logic io, input logic [12:0] exp,
                          input string tag);
    logic [12:0] act;
    @(negedge clk_i);
    addr_i = a; io_i = io;
    #1;
    act = {ucs_n_o, lcs_n_o, mcs_n_o, pcs_n_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h io=%0d act=%b exp=%b", tag, a, io, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run_cycle(input logic [19:0] a, input logic io, input int ext_low,
                           input int exp, input string tag);
    int n;
    @(negedge clk_i);
    addr_i = a; io_i = io; cyc_start_i = 1'b1; ext_ready_i = (ext_low == 0);
    @(posedge clk_i);
    @(negedge clk_i);
    cyc_start_i = 1'b0;
    n = 1;
    ext_ready_i = (n > ext_low);
    #1;
    while (!bus_ready_o && n < 20) begin
      @(negedge clk_i);
      n++;
      ext_ready_i = (n > ext_low);
      #1;
    end
    checks++;
    if (n != exp) begin
      errors++;
      $display("FAIL %s latency act=%0d exp=%0d", tag, n, exp);
    end
    @(posedge clk_i);
    ext_ready_i = 1'b1;
  endtask

  task automatic t_reset;
    logic [12:0] act;
    addr_i = 20'hFFC00; #1;
    act = {ucs_n_o, lcs_n_o, mcs_n_o, pcs_n_o};
    checks++;
    if (act !== NONE) begin
      errors++;
      $display("FAIL R1 in reset act=%b exp=%b", act, NONE);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    check_cs(20'hFFC00, 1'b0, cs_low(12), "R2 upper bottom");
    check_cs(20'hFFFFF, 1'b0, cs_low(12), "R2 upper top");
    check_cs(20'hFFBFF, 1'b0, NONE, "R2 below upper");
    check_cs(20'h00000, 1'b0, NONE, "R3 lower idle");
    check_cs(20'h20000, 1'b0, NONE, "R3 mid idle");
    check_cs(20'h40000, 1'b0, NONE, "R3 periph idle");
    run_cycle(20'hFFC00, 1'b0, 0, 4, "R2 R7 upper 3 waits");
    run_cycle(20'hFFC00, 1'b0, 6, 7, "R8 upper ext held");
  endtask

  task automatic t_nohit;
    check_cs(20'h80000, 1'b0, NONE, "R10 no select");
    run_cycle(20'h80000, 1'b0, 0, 1, "R10 zero waits");
    run_cycle(20'h80000, 1'b0, 3, 4, "R10 ext honoured");
    check_cs(20'hFFC00, 1'b1, NONE, "R12 io skips upper");
  endtask

  task automatic t_lower;
    write_reg(3'd1, 16'h03C4);
    check_cs(20'h03FFF, 1'b0, cs_low(11), "R4 lower top");
    check_cs(20'h04000, 1'b0, NONE, "R4 lower end");
    check_cs(20'h00000, 1'b0, cs_low(11), "R4 lower zero");
    run_cycle(20'h00010, 1'b0, 5, 1, "R9 lower ignores ext");
  endtask

  task automatic t_mid;
    write_reg(3'd2, 16'h2002);
    write_reg(3'd3, 16'h0002);
    check_cs(20'h20000, 1'b0, cs_low(7), "R5 quarter0");
    check_cs(20'h20400, 1'b0, cs_low(8), "R5 quarter1");
    check_cs(20'h20BFF, 1'b0, cs_low(9), "R5 quarter2");
    check_cs(20'h20FFF, 1'b0, cs_low(10), "R5 quarter3");
    check_cs(20'h21000, 1'b0, NONE, "R5 past block");
    check_cs(20'h1FFFF, 1'b0, NONE, "R5 below block");
    run_cycle(20'h20400, 1'b0, 0, 3, "R7 mid 2 waits");
    run_cycle(20'h20400, 1'b0, 5, 6, "R8 mid ext held");
  endtask

  task automatic t_periph;
    write_reg(3'd4, 16'h4001);
    check_cs(20'h40000, 1'b0, cs_low(0), "R6 window0");
    check_cs(20'h40080, 1'b0, cs_low(1), "R6 window1");
    check_cs(20'h40300, 1'b0, cs_low(6), "R6 window6");
    check_cs(20'h40380, 1'b0, NONE, "R6 eighth slot");
    check_cs(20'h40000, 1'b1, NONE, "R12 io vs mem periph");
    run_cycle(20'h40080, 1'b0, 0, 2, "R7 periph 1 wait");
    write_reg(3'd4, 16'h4021);
    check_cs(20'h40100, 1'b1, cs_low(2), "R6 io window2");
    check_cs(20'h40100, 1'b0, NONE, "R12 mem vs io periph");
  endtask

  task automatic t_misc;
    write_reg(3'd5, 16'hFFFF);
    write_reg(3'd7, 16'h0000);
    check_cs(20'h80000, 1'b0, NONE, "R13 sel5 ignored");
    check_cs(20'h20000, 1'b0, cs_low(7), "R13 sel7 ignored");
    write_reg(3'd0, 16'hFFFC);
    run_cycle(20'hFFC00, 1'b0, 4, 1, "R9 upper ignores ext");
    write_reg(3'd1, 16'hFFC4);
    check_cs(20'hFFC00, 1'b0, cs_low(12), "R11 upper over lower");
    check_cs(20'h20000, 1'b0, cs_low(11), "R11 lower over mid");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_nohit();
        t_lower();
        t_mid();
        t_periph();
        t_misc();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule